// File: doc/BRIEF.md
# Command-Tagged SPI Master Engine

This block is an SPI bus master fed by a queue of 32-bit command words. Each queued word carries one data frame plus the frame's own control: which target's select line to drive and whether that select stays asserted once the frame ends. The engine takes the next word, drives the select line, waits a programmed settle time, and shifts the frame out on MOSI while it shifts the reply in from MISO. Each reply is placed in a receive queue that the host drains one frame at a time.

Bit timing is paced from outside. The `half_tick` strobe advances SCK by one half period, so the SCK divider lives elsewhere. The three select delays are counted in core clock cycles. Each delay is a prescale factor times a power-of-two scale factor. Clock polarity, clock phase, bit order, frame length, the inactive level of each select line, and the two queue flush strobes are plain configuration inputs. Configuration should change only while no frame is in progress.

Top module: `spi_cmd_master`

## Requirements
- R1: A push word carries frame data in bits 15:0, a one-hot target mask in bits 23:16 (bit 16+n selects target n), and a hold-select flag in bit 31. The transmit queue holds TX_DEPTH (4) words, and a push while `tx_level` equals TX_DEPTH is discarded.
- R2: `cfg_frame_bits` holds the frame length minus one. Codes 0 and 1 act as code 2 (3 bits). Exactly that many bits are shifted, and the received frame appears right-aligned in `rx_data` with its upper bits zero.
- R3: SCK rests at `cfg_cpol` whenever no frame is shifting, and it toggles only while a select line is asserted.
- R4: With `cfg_cpha`=0 each bit is sampled on the leading SCK edge (the edge leaving the idle level) and MOSI changes on trailing edges. With `cfg_cpha`=1 MOSI changes on leading edges and bits are sampled on trailing edges.
- R5: With `cfg_lsb_first`=1 bit 0 of the frame goes first. Otherwise the top bit of the N-bit frame goes first. The received frame is assembled in the same order.
- R6: Every transmitted frame pushes exactly one entry into the receive queue, which holds RX_DEPTH (4) entries. `rx_data` shows the oldest entry, `pop` removes it, and `rx_level` counts the entries.
- R7: A frame that completes while the receive queue is full is dropped, and `rx_overflow` is then set. It stays set until `flush_rx` or reset.
- R8: Each delay lasts P×S core cycles, where prescale code 0..3 gives P = 1, 3, 5, 7 and scale code k gives S = 2^(k+1). With `half_tick` held high, the first SCK edge comes lead+1 cycles after select asserts, select negates trail cycles after the last SCK edge, and the next select assertion comes gap+1 cycles after the negation.
- R9: When a frame's hold-select flag is set, its select line stays asserted and the next queued frame starts shifting with no lead delay. The line negates only after a frame whose flag is clear.
- R10: `flush_tx` empties the transmit queue and `flush_rx` empties the receive queue, each by the next cycle.
- R11: Select line i rests at `cfg_cs_idle[i]` and is driven to the inverse level while its target is addressed.
- R12: After reset both queues are empty, `rx_overflow` is low, SCK is at `cfg_cpol`, and every select line is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | Shift least significant bit first |
| cfg_frame_bits | input | 4 | Frame length minus one |
| cfg_lead_pre | input | 2 | Select-to-first-SCK prescale code |
| cfg_lead_scl | input | 4 | Select-to-first-SCK scale code |
| cfg_trail_pre | input | 2 | Last-SCK-to-negate prescale code |
| cfg_trail_scl | input | 4 | Last-SCK-to-negate scale code |
| cfg_gap_pre | input | 2 | Idle-gap prescale code |
| cfg_gap_scl | input | 4 | Idle-gap scale code |
| cfg_cs_idle | input | CS_LINES (8) | Inactive level of each select line |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue and clear overflow |
| push_valid | input | 1 | Write `push_word` into the transmit queue |
| push_word | input | 32 | Command word |
| tx_level | output | $clog2(TX_DEPTH+1) (3) | Transmit queue fill count |
| pop | input | 1 | Remove the oldest received frame |
| rx_data | output | 16 | Oldest received frame |
| rx_level | output | $clog2(RX_DEPTH+1) (3) | Receive queue fill count |
| rx_overflow | output | 1 | Sticky dropped-frame flag |
| half_tick | input | 1 | Half SCK period strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | CS_LINES (8) | Select lines |

## Verification
A wrong shift index or phase choice shows on MOSI within the frame it corrupts, and the received word read from `rx_data` goes wrong when that frame ends. A wrong delay count moves the first or last SCK edge relative to the select edge by a measurable number of cycles, and this is visible on the first frame. Queue pointer or count errors show at `tx_level`, `rx_level` or the order of popped words as soon as the queue is filled or flushed. A lost hold flag shows up as an extra select negation between two chained frames.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int DATA_W   = 16;
   localparam int CONT_BIT = 31;
   localparam int MASK_LSB = 16;
   localparam int DLY_W    = 20;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LEAD, ST_SHIFT, ST_HOLD, ST_TRAIL, ST_GAP
   } eng_state_t;

   // prescale {1,3,5,7} = 2*code+1, scale = 2^(code+1)
   function automatic logic [DLY_W-1:0] dly_cycles(input logic [1:0] pre,
                                                   input logic [3:0] scl);
      logic [DLY_W-1:0] base;
      base = {{(DLY_W-3){1'b0}}, pre, 1'b1};
      return base << ({1'b0, scl} + 5'd1);
   endfunction
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_cmd_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_ok, rd_ok;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign wr_ok = push && !full && !flush;
   assign rd_ok = pop && !empty && !flush;
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
         if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int CS_LINES = 8,
   localparam int EW      = DATA_W + CS_LINES + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic                cfg_lsb_first,
   input  logic [3:0]          cfg_frame_bits,
   input  logic [1:0]          cfg_lead_pre,
   input  logic [3:0]          cfg_lead_scl,
   input  logic [1:0]          cfg_trail_pre,
   input  logic [3:0]          cfg_trail_scl,
   input  logic [1:0]          cfg_gap_pre,
   input  logic [3:0]          cfg_gap_scl,
   input  logic                half_tick,
   input  logic                ent_valid,
   input  logic [EW-1:0]       ent_word,
   output logic                ent_take,
   output logic                rx_push,
   output logic [DATA_W-1:0]   rx_word,
   output logic                sck,
   output logic                mosi,
   input  logic                miso,
   output logic [CS_LINES-1:0] sel
);
   eng_state_t          state;
   logic [DLY_W-1:0]    cnt;
   logic [DATA_W-1:0]   tx_q, rx_q, rx_next;
   logic [5:0]          ecnt;
   logic [4:0]          bitno, nbits;
   logic [5:0]          edges_m1;
   logic [3:0]          idx;
   logic                sck_q, cont_q;
   logic                step, sample_e, last_e, advance;
   logic [DLY_W-1:0]    d_lead, d_trail, d_gap;

   assign d_lead  = dly_cycles(cfg_lead_pre, cfg_lead_scl);
   assign d_trail = dly_cycles(cfg_trail_pre, cfg_trail_scl);
   assign d_gap   = dly_cycles(cfg_gap_pre, cfg_gap_scl);

   assign nbits    = (cfg_frame_bits < 4'd2) ? 5'd3 : ({1'b0, cfg_frame_bits} + 5'd1);
   assign edges_m1 = {nbits, 1'b0} - 6'd1;
   assign idx      = cfg_lsb_first ? bitno[3:0] : 4'(nbits - 5'd1 - bitno);
   assign step     = (state == ST_SHIFT) && half_tick;
   assign sample_e = (~ecnt[0]) ^ cfg_cpha;
   assign last_e   = (ecnt == edges_m1);
   assign advance  = !sample_e && (ecnt != 6'd0) && !last_e;
   assign ent_take = ((state == ST_IDLE) || (state == ST_HOLD)) && ent_valid;

   always_comb begin
      rx_next = rx_q;
      if (step && sample_e) rx_next[idx] = miso;
   end

   assign rx_push = step && last_e;
   assign rx_word = rx_next;
   assign mosi    = tx_q[idx];
   assign sck     = (state == ST_SHIFT) ? sck_q : cfg_cpol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         ecnt   <= '0;
         bitno  <= '0;
         sck_q  <= 1'b0;
         cont_q <= 1'b0;
         sel    <= '0;
      end else begin
         if (ent_take) begin
            tx_q   <= ent_word[DATA_W-1:0];
            sel    <= ent_word[DATA_W +: CS_LINES];
            cont_q <= ent_word[EW-1];
            rx_q   <= '0;
            ecnt   <= '0;
            bitno  <= '0;
            sck_q  <= cfg_cpol;
         end
         unique case (state)
            ST_IDLE: if (ent_take) begin
               state <= ST_LEAD;
               cnt   <= d_lead - DLY_W'(1);
            end
            ST_LEAD: begin
               if (cnt == '0) state <= ST_SHIFT;
               else           cnt   <= cnt - DLY_W'(1);
            end
            ST_SHIFT: if (step) begin
               sck_q <= ~sck_q;
               ecnt  <= ecnt + 6'd1;
               rx_q  <= rx_next;
               if (advance) bitno <= bitno + 5'd1;
               if (last_e) begin
                  if (cont_q) state <= ST_HOLD;
                  else begin
                     state <= ST_TRAIL;
                     cnt   <= d_trail - DLY_W'(1);
                  end
               end
            end
            ST_HOLD: if (ent_take) state <= ST_SHIFT;
            ST_TRAIL: begin
               if (cnt == '0) begin
                  state <= ST_GAP;
                  sel   <= '0;
                  cnt   <= d_gap - DLY_W'(1);
               end else cnt <= cnt - DLY_W'(1);
            end
            ST_GAP: begin
               if (cnt == '0) state <= ST_IDLE;
               else           cnt   <= cnt - DLY_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
   import spi_cmd_pkg::*;
#(
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 4,
   parameter int CS_LINES = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_cpol,
   input  logic                             cfg_cpha,
   input  logic                             cfg_lsb_first,
   input  logic [3:0]                       cfg_frame_bits,
   input  logic [1:0]                       cfg_lead_pre,
   input  logic [3:0]                       cfg_lead_scl,
   input  logic [1:0]                       cfg_trail_pre,
   input  logic [3:0]                       cfg_trail_scl,
   input  logic [1:0]                       cfg_gap_pre,
   input  logic [3:0]                       cfg_gap_scl,
   input  logic [CS_LINES-1:0]              cfg_cs_idle,
   input  logic                             flush_tx,
   input  logic                             flush_rx,
   input  logic                             push_valid,
   input  logic [31:0]                      push_word,
   output logic [$clog2(TX_DEPTH+1)-1:0]    tx_level,
   input  logic                             pop,
   output logic [DATA_W-1:0]                rx_data,
   output logic [$clog2(RX_DEPTH+1)-1:0]    rx_level,
   output logic                             rx_overflow,
   input  logic                             half_tick,
   output logic                             sck,
   output logic                             mosi,
   input  logic                             miso,
   output logic [CS_LINES-1:0]              cs_out
);
   localparam int EW = DATA_W + CS_LINES + 1;

   generate
      if (CS_LINES < 1 || CS_LINES > 8) begin : g_bad_cs
         $error("spi_cmd_master: CS_LINES must be 1..8");
      end
   endgenerate

   logic [EW-1:0]       tx_in, tx_head;
   logic                tx_full, tx_empty, rx_full, rx_empty;
   logic                take, eng_rx_push;
   logic [DATA_W-1:0]   eng_rx_word;
   logic [CS_LINES-1:0] sel;

   assign tx_in = {push_word[CONT_BIT], push_word[MASK_LSB +: CS_LINES],
                   push_word[DATA_W-1:0]};

   spi_cmd_fifo #(.W(EW), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush_tx),
      .push(push_valid), .din(tx_in),
      .pop(take), .dout(tx_head),
      .count(tx_level), .full(tx_full), .empty(tx_empty)
   );

   spi_cmd_engine #(.CS_LINES(CS_LINES)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
      .cfg_frame_bits(cfg_frame_bits),
      .cfg_lead_pre(cfg_lead_pre), .cfg_lead_scl(cfg_lead_scl),
      .cfg_trail_pre(cfg_trail_pre), .cfg_trail_scl(cfg_trail_scl),
      .cfg_gap_pre(cfg_gap_pre), .cfg_gap_scl(cfg_gap_scl),
      .half_tick(half_tick),
      .ent_valid(!tx_empty), .ent_word(tx_head), .ent_take(take),
      .rx_push(eng_rx_push), .rx_word(eng_rx_word),
      .sck(sck), .mosi(mosi), .miso(miso), .sel(sel)
   );

   spi_cmd_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush_rx),
      .push(eng_rx_push), .din(eng_rx_word),
      .pop(pop), .dout(rx_data),
      .count(rx_level), .full(rx_full), .empty(rx_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rx_overflow <= 1'b0;
      else if (flush_rx)                  rx_overflow <= 1'b0;
      else if (eng_rx_push && rx_full)    rx_overflow <= 1'b1;
   end

   for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
      assign cs_out[i] = cfg_cs_idle[i] ^ sel[i];
   end
endmodule

// File: rtl/spi_cmd_checker.sv
module spi_cmd_checker #(
   parameter int TX_DEPTH = 4,
   parameter int RX_DEPTH = 4,
   parameter int CS_LINES = 8
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_cpol,
   input logic [CS_LINES-1:0]           cfg_cs_idle,
   input logic                          flush_tx,
   input logic                          flush_rx,
   input logic [$clog2(TX_DEPTH+1)-1:0] tx_level,
   input logic [$clog2(RX_DEPTH+1)-1:0] rx_level,
   input logic                          rx_overflow,
   input logic                          sck
,  input logic [CS_LINES-1:0]           cs_out
);
   p_tx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= TX_DEPTH);

   p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_level <= RX_DEPTH);

   p_sck_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sck) && $stable(cfg_cpol)) |-> (cs_out != cfg_cs_idle));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overflow && !flush_rx) |=> rx_overflow);

   p_flush_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx |=> (tx_level == 0));

   p_flush_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_rx |=> (rx_level == 0 && !rx_overflow));
endmodule

bind spi_cmd_master spi_cmd_checker #(
   .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .CS_LINES(CS_LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cs_idle(cfg_cs_idle),
   .flush_tx(flush_tx), .flush_rx(flush_rx), .tx_level(tx_level),
   .rx_level(rx_level), .rx_overflow(rx_overflow), .sck(sck), .cs_out(cs_out)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
   logic [3:0]  cfg_frame_bits = 4'd7;
   logic [1:0]  cfg_lead_pre = 2'd0, cfg_trail_pre = 2'd0, cfg_gap_pre = 2'd0;
   logic [3:0]  cfg_lead_scl = 4'd0, cfg_trail_scl = 4'd0, cfg_gap_scl = 4'd0;
   logic [7:0]  cfg_cs_idle = 8'hFF;
   logic        flush_tx = 1'b0, flush_rx = 1'b0, push_valid = 1'b0, pop = 1'b0;
   logic [31:0] push_word = '0;
   logic [2:0]  tx_level, rx_level;
   logic [15:0] rx_data;
   logic        rx_overflow, sck, mosi, miso;
   logic        half_tick = 1'b1;
   logic [7:0]  cs_out;

   assign miso = mosi;   // loopback

   always #4 clk = ~clk;   // 125 MHz

   spi_cmd_master u0 (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .cfg_frame_bits(cfg_frame_bits),
      .cfg_lead_pre(cfg_lead_pre), .cfg_lead_scl(cfg_lead_scl),
      .cfg_trail_pre(cfg_trail_pre), .cfg_trail_scl(cfg_trail_scl),
      .cfg_gap_pre(cfg_gap_pre), .cfg_gap_scl(cfg_gap_scl),
      .cfg_cs_idle(cfg_cs_idle), .flush_tx(flush_tx), .flush_rx(flush_rx),
      .push_valid(push_valid), .push_word(push_word), .tx_level(tx_level),
      .pop(pop), .rx_data(rx_data), .rx_level(rx_level),
      .rx_overflow(rx_overflow), .half_tick(half_tick), .sck(sck),
      .mosi(mosi), .miso(miso), .cs_out(cs_out)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- bus monitor ----------------
   int  cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  t_assert = 0, t_negate = 0, t_first = 0, t_last = 0, last_gap = 0;
   int  n_assert = 0, n_negate = 0, ncap = 0;
   bit  seen_edge = 0, prev_act = 0, prev_sck = 0;
   bit  cap [1024];

   always @(negedge clk) begin
      bit act, lead_e;
      act = (cs_out !== cfg_cs_idle);
      if (rst_n) begin
         if (act && !prev_act) begin
            if (n_negate > 0) last_gap = cyc - t_negate;
            t_assert = cyc; n_assert++; seen_edge = 0;
         end
         if (!act && prev_act) begin
            t_negate = cyc; n_negate++;
         end
         if (act && sck !== prev_sck) begin
            if (!seen_edge) begin t_first = cyc; seen_edge = 1; end
            t_last = cyc;
            lead_e = (sck !== cfg_cpol);
            if (lead_e ^ cfg_cpha) begin
               cap[ncap % 1024] = mosi;
               ncap++;
            end
         end
      end
      prev_act = act;
      prev_sck = sck;
   end

   function automatic logic [31:0] bits_of(input int start, input int n, input bit lsb);
      logic [31:0] v = '0;
      for (int i = 0; i < n; i++) begin
         if (lsb) v[i] = cap[(start + i) % 1024];
         else     v = {v[30:0], cap[(start + i) % 1024]};
      end
      return v;
   endfunction

   function automatic int dly(input int p, input int s);
      return (2 * p + 1) * (2 << s);
   endfunction

   // ---------------- drivers ----------------
   task automatic push(input logic [31:0] w);
      @(negedge clk); push_valid = 1'b1; push_word = w;
      @(negedge clk); push_valid = 1'b0;
   endtask

   task automatic do_pop();
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
   endtask

   task automatic wait_negates(input int target);
      int guard = 0;
      while (n_negate < target && guard < 20000) begin
         @(negedge clk); guard++;
      end
      repeat (20) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk("R12 sck idle", sck, 0);
      chk("R12 cs idle", cs_out, 8'hFF);
      chk("R12 tx_level", tx_level, 0);
      chk("R12 rx_level", rx_level, 0);
      chk("R12 overflow", rx_overflow, 0);
   endtask

   task automatic t_basic();
      int s0 = ncap, a0 = n_assert, ng = n_negate;
      cfg_lead_pre = 2'd1; cfg_lead_scl = 4'd1;   // 12
      cfg_trail_pre = 2'd2; cfg_trail_scl = 4'd0; // 10
      push(32'h0001_00A5);
      @(negedge clk);
      chk("R11 line0 active low", cs_out, 8'hFE);
      wait_negates(ng + 1);
      chk("R8 lead", t_first - t_assert, dly(1, 1) + 1);
      chk("R8 trail", t_negate - t_last, dly(2, 0));
      chk("R5 msb-first mosi", bits_of(s0, 8, 0), 32'hA5);
      chk("R2 bit count 8", ncap - s0, 8);
      chk("R6 one entry", rx_level, 1);
      chk("R6 rx data", rx_data, 16'h00A5);
      chk("R1 single assert", n_assert - a0, 1);
      do_pop();
      chk("R6 pop empties", rx_level, 0);
      cfg_lead_pre = 2'd0; cfg_lead_scl = 4'd0;
      cfg_trail_pre = 2'd0; cfg_trail_scl = 4'd0;
   endtask

   task automatic t_modes();
      int s0 = ncap, ng = n_negate;
      cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_lsb_first = 1'b1; cfg_frame_bits = 4'd11;
      @(negedge clk); @(negedge clk);
      chk("R3 sck idle high", sck, 1);
      push(32'h0002_F3C5);
      wait_negates(ng + 1);
      chk("R4 R5 lsb-first cpha1 mosi", bits_of(s0, 12, 1), 32'h3C5);
      chk("R2 bit count 12", ncap - s0, 12);
      chk("R2 rx 12-bit right aligned", rx_data, 16'h03C5);
      chk("R3 sck back to idle", sck, 1);
      do_pop();
      cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_frame_bits = 4'd7;
   endtask

   task automatic t_short();
      int s0 = ncap, ng = n_negate;
      cfg_frame_bits = 4'd0;
      push(32'h0001_FFFF);
      wait_negates(ng + 1);
      chk("R2 code 0 gives 3 bits", ncap - s0, 3);
      chk("R2 rx 3 bits", rx_data, 16'h0007);
      do_pop();
      cfg_frame_bits = 4'd7;
   endtask

   task automatic t_cont();
      int s0 = ncap, a0 = n_assert, ng = n_negate;
      cfg_frame_bits = 4'd15; cfg_cpha = 1'b1;
      push(32'h8001_BEEF);
      push(32'h0001_1234);
      wait_negates(ng + 1);
      chk("R9 one assertion for chain", n_assert - a0, 1);
      chk("R9 mosi 32 bits", bits_of(s0, 32, 0), 32'hBEEF_1234);
      chk("R6 two entries", rx_level, 2);
      chk("R9 first frame", rx_data, 16'hBEEF);
      do_pop();
      chk("R9 second frame", rx_data, 16'h1234);
      do_pop();
      cfg_frame_bits = 4'd7; cfg_cpha = 1'b0;
   endtask

   task automatic t_gap();
      int ng = n_negate;
      cfg_gap_pre = 2'd0; cfg_gap_scl = 4'd2;   // 8
      push(32'h0001_0011);
      push(32'h0001_0022);
      wait_negates(ng + 2);
      chk("R8 gap", last_gap, dly(0, 2) + 1);
      do_pop(); do_pop();
      chk("R6 drained", rx_level, 0);
      cfg_gap_scl = 4'd0;
   endtask

   task automatic t_drop_flush();
      int ng = n_negate, a0 = n_assert;
      cfg_lead_pre = 2'd1; cfg_lead_scl = 4'd3;   // 48
      @(negedge clk);
      push_valid = 1'b1;
      for (int i = 0; i < 6; i++) begin
         push_word = 32'h0001_0040 + 32'(i);
         @(negedge clk);
      end
      push_valid = 1'b0;
      chk("R1 push at full dropped", tx_level, 4);
      flush_tx = 1'b1; @(negedge clk); flush_tx = 1'b0;
      chk("R10 tx flushed", tx_level, 0);
      wait_negates(ng + 1);
      chk("R10 only taken frame runs", n_assert - a0, 1);
      chk("R10 rx one", rx_level, 1);
      chk("R1 first word sent", rx_data, 16'h0040);
      do_pop();
      cfg_lead_pre = 2'd0; cfg_lead_scl = 4'd0;
   endtask

   task automatic t_overflow();
      int ng = n_negate;
      for (int i = 0; i < 4; i++) push(32'h0001_0060 + 32'(i));
      wait_negates(ng + 4);
      chk("R7 no overflow at exactly full", rx_overflow, 0);
      push(32'h0001_0099);
      wait_negates(ng + 5);
      chk("R7 overflow set", rx_overflow, 1);
      chk("R7 level stays full", rx_level, 4);
      do_pop();
      chk("R7 overflow sticky across pop", rx_overflow, 1);
      chk("R6 order second", rx_data, 16'h0061);
      do_pop(); do_pop();
      chk("R7 last kept entry", rx_data, 16'h0063);
      flush_rx = 1'b1; @(negedge clk); flush_rx = 1'b0;
      chk("R10 rx flushed", rx_level, 0);
      chk("R10 overflow cleared", rx_overflow, 0);
   endtask

   task automatic t_idle_level();
      int ng = n_negate;
      cfg_cs_idle = 8'h05;
      @(negedge clk);
      chk("R11 custom idle", cs_out, 8'h05);
      push(32'h0004_0033);
      @(negedge clk);
      chk("R11 line2 driven inverse", cs_out, 8'h01);
      wait_negates(ng + 1);
      chk("R11 back to idle", cs_out, 8'h05);
      do_pop();
      cfg_cs_idle = 8'hFF;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_modes();
      t_short();
      t_cont();
      t_gap();
      t_drop_flush();
      t_overflow();
      t_idle_level();
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R6 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule